// File: doc/BRIEF.md
# System Control Register File

This block is a bank of system control and status words behind a plain 32-bit register port. The port decodes a 4 KiB byte window. The lower half of the window holds general read/write storage with fixed reset values. The upper half holds a single command word at byte offset 0xF00. When software writes certain values to that word, the block sends a one-cycle request pulse to the chip's reset sequencer or power controller. Every other offset in the upper half is unmapped.

A small set of status words always reads back with two fixed bits set, whatever was last written to them. Software writes to these words as to any other storage word. The forced bits are applied only on the read path.

Accesses are whole 32-bit words. A request is accepted in any cycle where valid is high. A read returns its data in the next cycle, together with a read-valid strobe.

Top module: `sysctl_regfile`

## Requirements
- R1: After reset, the word at byte offset 0x100 holds 0x05F20121, the word at 0x104 holds 0x00000002, the word at 0x108 holds 0x05F30121, and the word at 0x10C holds 0x05F40121. Every other storage word holds zero.
- R2: Byte offsets 0x000 to 0x7FF map to 512 storage words, where the word index is the offset shifted right by two. Address bits 1:0 are ignored on both writes and reads. A write is stored and reads back unchanged, except as stated in R3.
- R3: A read of byte offset 0x100, 0x108 or 0x10C returns the stored word ORed with 0x30000000. A read of any other storage offset, including 0x104, returns the stored word unchanged.
- R4: A write of 1 or 2 to byte offset 0xF00 drives the reset request high for exactly the one cycle after the write is accepted.
- R5: A write of 3 to byte offset 0xF00 drives the shutdown request high for exactly the one cycle after the write is accepted.
- R6: A write of any other value to offset 0xF00 raises neither request. The two requests are never high in the same cycle, and neither is high without a command write.
- R7: Every value written to offset 0xF00 is kept and returned by later reads of that offset. Its reset value is zero.
- R8: Byte offsets 0x800 to 0xFFF, other than 0xF00, ignore writes and read as zero. A write there leaves every storage word unchanged.
- R9: The read-valid strobe is high in exactly the cycle after a read request is accepted, and read data is valid in that cycle. Writes and idle cycles leave the strobe low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Request strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid when bus_rvalid is high |
| bus_rvalid | output | 1 | Read data strobe, one cycle after a read |
| sys_reset_req | output | 1 | One-cycle system reset request |
| sys_shutdown_req | output | 1 | One-cycle system shutdown request |

## Verification
The hardest case to reach from the ports is aliasing in the upper half of the window. The low index bits of an unmapped offset match those of a real storage word, so a decode fault would silently corrupt storage. Such a fault shows up only on a later read of the lower half.

The stimulus fills all 512 storage words with a known pattern. It then writes a different pattern to every unmapped upper word and checks that each one reads as zero. Finally it reads the whole storage range again to confirm nothing changed.

The command word gets a sweep of values, including every non-request value next to the request codes. Both request outputs are sampled in the pulse cycle and in the cycle after it.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  typedef enum logic [1:0] {
    RSEL_NONE  = 2'd0,
    RSEL_STORE = 2'd1,
    RSEL_CMD   = 2'd2
  } rsel_e;

  // Word indices (byte offset / 4) of the identity/status words
  localparam int unsigned STAT_W_A = 'h40;
  localparam int unsigned STAT_W_B = 'h41;
  localparam int unsigned STAT_W_C = 'h42;
  localparam int unsigned STAT_W_D = 'h43;

  localparam logic [31:0] FORCE_MASK = 32'h3000_0000;

  // Command codes written to the command word
  localparam logic [31:0] CODE_RESET_A = 32'd1;
  localparam logic [31:0] CODE_RESET_B = 32'd2;
  localparam logic [31:0] CODE_HALT    = 32'd3;

  function automatic logic [31:0] reset_default(int unsigned w);
    case (w)
      STAT_W_A: return 32'h05F2_0121;
      STAT_W_B: return 32'h0000_0002;
      STAT_W_C: return 32'h05F3_0121;
      STAT_W_D: return 32'h05F4_0121;
      default:  return 32'h0000_0000;
    endcase
  endfunction

  function automatic logic is_forced(int unsigned w);
    return (w == STAT_W_A) || (w == STAT_W_C) || (w == STAT_W_D);
  endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned STORE_WORDS = 512,
  parameter int unsigned CMD_OFFSET  = 'hF00,
  localparam int unsigned WORD_W     = ADDR_W - 2,
  localparam int unsigned IDX_W      = $clog2(STORE_WORDS)
) (
  input  logic              valid,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output logic              st_wr,
  output logic              cmd_wr,
  output logic              rd_en,
  output rsel_e             rsel,
  output logic [IDX_W-1:0]  idx,
  output logic              force_hit
);

  localparam logic [WORD_W-1:0] STORE_LIM = WORD_W'(STORE_WORDS);
  localparam logic [WORD_W-1:0] CMD_WORD  = WORD_W'(CMD_OFFSET >> 2);

  logic [WORD_W-1:0] word;
  logic              in_store;
  logic              is_cmd;
  logic              unused_lo;

  assign word      = addr[ADDR_W-1:2];
  assign unused_lo = ^addr[1:0];
  assign in_store  = (word < STORE_LIM);
  assign is_cmd    = (word == CMD_WORD);

  assign idx       = word[IDX_W-1:0];
  assign force_hit = in_store && is_forced(32'(word));

  assign st_wr  = valid && we && in_store;
  assign cmd_wr = valid && we && is_cmd;
  assign rd_en  = valid && !we;

  always_comb begin
    if (in_store)    rsel = RSEL_STORE;
    else if (is_cmd) rsel = RSEL_CMD;
    else             rsel = RSEL_NONE;
  end

endmodule

// File: rtl/sysctl_store.sv
module sysctl_store
  import sysctl_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WORDS  = 512,
  localparam int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_word
);

  logic [DATA_W-1:0] mem [WORDS];

  // Every word carries a reset value, so the array maps to flops
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WORDS; i++) begin
        mem[i] <= DATA_W'(reset_default(i));
      end
    end else if (wr_en) begin
      mem[idx] <= wdata;
    end
  end

  assign rd_word = mem[idx];

endmodule

// File: rtl/sysctl_cmd.sv
module sysctl_cmd
  import sysctl_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cmd_value,
  output logic              reset_req,
  output logic              halt_req
);

  logic want_reset;
  logic want_halt;

  assign want_reset = (wdata == DATA_W'(CODE_RESET_A)) ||
                      (wdata == DATA_W'(CODE_RESET_B));
  assign want_halt  = (wdata == DATA_W'(CODE_HALT));

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_value <= '0;
      reset_req <= 1'b0;
      halt_req  <= 1'b0;
    end else begin
      reset_req <= cmd_wr && want_reset;
      halt_req  <= cmd_wr && want_halt;
      if (cmd_wr) cmd_value <= wdata;
    end
  end

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned STORE_WORDS = 512,
  parameter int unsigned CMD_OFFSET  = 'hF00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              sys_reset_req,
  output logic              sys_shutdown_req
);

  localparam int unsigned IDX_W = $clog2(STORE_WORDS);
  localparam logic [DATA_W-1:0] RD_MASK = DATA_W'(FORCE_MASK);

  logic              st_wr;
  logic              cmd_wr;
  logic              rd_en;
  rsel_e             rsel;
  logic [IDX_W-1:0]  idx;
  logic              force_hit;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] cmd_value;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  sysctl_decode #(
    .ADDR_W     (ADDR_W),
    .STORE_WORDS(STORE_WORDS),
    .CMD_OFFSET (CMD_OFFSET)
  ) u_decode (
    .valid    (bus_valid),
    .we       (bus_we),
    .addr     (bus_addr),
    .st_wr    (st_wr),
    .cmd_wr   (cmd_wr),
    .rd_en    (rd_en),
    .rsel     (rsel),
    .idx      (idx),
    .force_hit(force_hit)
  );

  sysctl_store #(
    .DATA_W(DATA_W),
    .WORDS (STORE_WORDS)
  ) u_store (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (st_wr),
    .idx    (idx),
    .wdata  (bus_wdata),
    .rd_word(rd_word)
  );

  sysctl_cmd #(
    .DATA_W(DATA_W)
  ) u_cmd (
    .clk      (clk),
    .rst      (rst),
    .cmd_wr   (cmd_wr),
    .wdata    (bus_wdata),
    .cmd_value(cmd_value),
    .reset_req(sys_reset_req),
    .halt_req (sys_shutdown_req)
  );

  // Registered read return with status-bit forcing
  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_en;
      if (rd_en) begin
        case (rsel)
          RSEL_STORE: rdata_q <= rd_word | (force_hit ? RD_MASK : '0);
          RSEL_CMD:   rdata_q <= cmd_value;
          default:    rdata_q <= '0;
        endcase
      end
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;

endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned STORE_WORDS = 512,
  parameter int unsigned CMD_OFFSET  = 'hF00
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_rvalid,
  input logic              sys_reset_req,
  input logic              sys_shutdown_req
);

  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] C_WORD = WORD_W'(CMD_OFFSET >> 2);
  localparam logic [WORD_W-1:0] C_LIM  = WORD_W'(STORE_WORDS);
  localparam logic [DATA_W-1:0] C_MASK = DATA_W'(FORCE_MASK);

  logic [WORD_W-1:0] w;
  logic cmd_hit, rd_forced, rd_hole, is_rst_code, is_halt_code;

  assign w            = bus_addr[ADDR_W-1:2];
  assign cmd_hit      = bus_valid && bus_we && (w == C_WORD);
  assign is_rst_code  = (bus_wdata == DATA_W'(1)) || (bus_wdata == DATA_W'(2));
  assign is_halt_code = (bus_wdata == DATA_W'(3));
  assign rd_forced    = bus_valid && !bus_we && (w < C_LIM) && is_forced(32'(w));
  assign rd_hole      = bus_valid && !bus_we && (w >= C_LIM) && (w != C_WORD);

  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_we) |=> bus_rvalid);                           // R9
  AST_RVALID_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> $past(bus_valid && !bus_we));                      // R9
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sys_reset_req, sys_shutdown_req}));                     // R6
  AST_RESET_REQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    sys_reset_req |-> $past(cmd_hit && is_rst_code));                 // R4
  AST_SHUTDOWN_REQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    sys_shutdown_req |-> $past(cmd_hit && is_halt_code));             // R5
  AST_FORCED_BITS: assert property (@(posedge clk) disable iff (rst)
    (bus_rvalid && $past(rd_forced)) |-> ((bus_rdata & C_MASK) == C_MASK)); // R3
  AST_HOLE_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rvalid && $past(rd_hole)) |-> (bus_rdata == '0));            // R8

endmodule

bind sysctl_regfile sysctl_regfile_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .STORE_WORDS(STORE_WORDS),
  .CMD_OFFSET (CMD_OFFSET)
) u_chk (
  .clk             (clk),
  .rst             (rst),
  .bus_valid       (bus_valid),
  .bus_we          (bus_we),
  .bus_addr        (bus_addr),
  .bus_wdata       (bus_wdata),
  .bus_rdata       (bus_rdata),
  .bus_rvalid      (bus_rvalid),
  .sys_reset_req   (sys_reset_req),
  .sys_shutdown_req(sys_shutdown_req)
);

// File: tb/sim_sysctl_regfile.sv
`timescale 1ns/1ps
module sim_sysctl_regfile;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        sys_reset_req;
  logic        sys_shutdown_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sysctl_regfile u0 (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .sys_reset_req(sys_reset_req),
    .sys_shutdown_req(sys_shutdown_req)
  );

  function automatic logic [31:0] dflt(int w);
    case (w)
      'h40: return 32'h05F2_0121;
      'h41: return 32'h0000_0002;
      'h42: return 32'h05F3_0121;
      'h43: return 32'h05F4_0121;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] fmask(int w);
    return (w == 'h40 || w == 'h42 || w == 'h43) ? 32'h3000_0000 : 32'h0;
  endfunction

  function automatic logic [31:0] pat(int w);
    return 32'hC35A_0000 ^ (32'(w) * 32'h0001_0203);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] d,
                          output logic rq, output logic sq);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_we = 1'b0;
    rq = sys_reset_req; sq = sys_shutdown_req;
    check(bus_rvalid == 1'b0, "R9 no strobe on write", 32'(bus_rvalid), 0);
  endtask

  task automatic do_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
    check(bus_rvalid == 1'b1, "R9 strobe after read", 32'(bus_rvalid), 1);
  endtask

  initial begin
    logic [31:0] rd;
    logic rq, sq;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // Reset state of outputs
    check(!bus_rvalid && !sys_reset_req && !sys_shutdown_req, "R9 reset outputs",
          {29'd0, bus_rvalid, sys_reset_req, sys_shutdown_req}, 0);

    // R1/R3: defaults of all storage words
    for (int w = 0; w < 512; w++) begin
      do_read(12'(w * 4), rd);
      check(rd == (dflt(w) | fmask(w)), "R1 reset default", rd, dflt(w) | fmask(w));
    end
    do_read(12'hF00, rd);
    check(rd == 32'h0, "R7 command reset value", rd, 0);

    // R2: fill storage, low address bits vary
    for (int w = 0; w < 512; w++) begin
      do_write(12'(w * 4 + (w % 4)), pat(w), rq, sq);
      check(!rq && !sq, "R6 no request on storage write", {30'd0, rq, sq}, 0);
    end
    for (int w = 0; w < 512; w++) begin
      do_read(12'(w * 4 + ((w + 1) % 4)), rd);
      check(rd == (pat(w) | fmask(w)), "R2 R3 readback", rd, pat(w) | fmask(w));
    end

    // R8: unmapped upper words ignore writes and read zero
    for (int w = 512; w < 1024; w++) begin
      if (w == 'h3C0) continue;
      do_write(12'(w * 4), ~pat(w), rq, sq);
      do_read(12'(w * 4), rd);
      check(rd == 32'h0, "R8 hole reads zero", rd, 0);
    end
    for (int w = 0; w < 512; w++) begin
      do_read(12'(w * 4), rd);
      check(rd == (pat(w) | fmask(w)), "R8 storage untouched", rd, pat(w) | fmask(w));
    end

    // R4/R5/R6/R7: command sweep
    for (int k = 0; k < 12; k++) begin
      logic [31:0] v;
      logic er, es;
      v  = (k < 9) ? 32'(k) : (k == 9) ? 32'hFFFF_FFFF : (k == 10) ? 32'h0000_0101
                                       : 32'h8000_0003;
      er = (v == 1) || (v == 2);
      es = (v == 3);
      do_write((k % 2) ? 12'hF03 : 12'hF00, v, rq, sq);
      check(rq == er, "R4 R6 reset pulse", 32'(rq), 32'(er));
      check(sq == es, "R5 R6 shutdown pulse", 32'(sq), 32'(es));
      @(negedge clk);
      check(!sys_reset_req && !sys_shutdown_req, "R4 R5 single cycle",
            {30'd0, sys_reset_req, sys_shutdown_req}, 0);
      do_read(12'hF00, rd);
      check(rd == v, "R7 command readback", rd, v);
    end

    // Forced bits stay applied after writing zero
    do_write(12'h108, 32'h0, rq, sq);
    do_read(12'h108, rd);
    check(rd == 32'h3000_0000, "R3 forced over zero", rd, 32'h3000_0000);
    do_write(12'h104, 32'h0, rq, sq);
    do_read(12'h104, rd);
    check(rd == 32'h0, "R3 unforced word", rd, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule